// File: doc/BRIEF.md
# Bus-Mastering Block Copy Engine

This block copies a run of words from a source region of memory to a destination region while the processor is kept off the bus. Software loads a source address, a destination address, a word count and an optional pacing interval through a small register port, then writes the go bit of the control register. The engine asks for the system bus with a request line and waits for the processor's grant. Only then does it drive the bus. Each word moves as a read cycle at the source address followed by a write cycle at the destination address, and both addresses then step by one.

Two pacing modes exist. In burst mode the engine keeps the bus from the first grant to the last write, moving one word every two cycles. In paced mode it gives the bus back after every word and stays off the bus for a programmed number of cycles before it asks again, so the processor can use those cycles. On completion the engine drops its request, shows done in the status register and pulses an interrupt line.

The bus is a simple synchronous one. Read data is returned by memory in the cycle after the read strobe, and the engine forwards that data as write data in the same cycle.

Top module: `dma_mover`

## Requirements
- R1: After reset, bus_req, m_rd, m_wr and irq are low, and the status register (offset 3) reads busy (bit 0) = 0 and done (bit 1) = 0.
- R2: The register offsets are fixed: source address at offset 0, destination at 1, word count at 2, control/status at 3, pacing interval at 4. Source, destination and pacing values read back as written. A control write stores bit 1 as the paced-mode flag, which reads back at status bit 2. Bit 0 of a control write is the go bit.
- R3: A go with a nonzero count raises bus_req in the cycle after the control write. While bus_gnt is low, m_rd and m_wr stay low.
- R4: Word i (counting from 0) is moved by a cycle with m_rd at source+i, and in the next cycle by m_wr at destination+i. In that write cycle m_wdata equals the word read.
- R5: In burst mode (paced flag 0), bus_req rises once and stays high from the request until the last write cycle.
- R6: In paced mode, bus_req falls after each word's write and stays low for exactly max(P,1) cycles before rising again, where P is the pacing interval. bus_req rises once per word.
- R7: In the cycle after the last write, bus_req is low, irq is high for exactly one cycle, and the status reads busy = 0 and done = 1. The destination region then holds the source words, and the word after that region is unchanged.
- R8: A go with a count of zero raises irq in the next cycle and sets done without ever raising bus_req.
- R9: A go written while a transfer is in progress is ignored. The running transfer moves exactly its original count and raises irq once.
- R10: The engine waits in request for any number of cycles before the grant arrives, and it loses no word because of the wait.
- R11: While busy, reading offset 2 returns the number of words not yet written. When the engine is idle, offset 2 returns the programmed count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | CFG_W | Register write data |
| cfg_rdata | output | CFG_W | Register read data (combinational) |
| bus_req | output | 1 | Bus mastership request |
| bus_gnt | input | 1 | Bus mastership grant from the processor |
| m_addr | output | ADDR_W | Bus address |
| m_rd | output | 1 | Bus read strobe |
| m_wr | output | 1 | Bus write strobe |
| m_wdata | output | DATA_W | Bus write data |
| m_rdata | input | DATA_W | Bus read data, valid the cycle after m_rd |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The assertions rely on two properties of the arbiter: it holds bus_gnt high for as long as bus_req stays high once granted, and it never grants while bus_req is low after having seen it low. They also rely on the memory returning read data exactly one cycle after the read strobe. The bench's arbiter model is a registered grant that follows the request after a chosen latency and drops one cycle after the request falls. Its memory model is a registered array, so every stimulus stays within these assumptions. The sweep covers word counts 0, 1, 2 and 5, both pacing modes with intervals 0 and 2, and grant latencies 0 and 3.

// File: rtl/dma_mover_pkg.sv
package dma_mover_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RD,
    ST_WR,
    ST_GAP
  } eng_state_t;

  localparam logic [2:0] REG_SRC  = 3'd0;
  localparam logic [2:0] REG_DST  = 3'd1;
  localparam logic [2:0] REG_LEN  = 3'd2;
  localparam logic [2:0] REG_CTRL = 3'd3;
  localparam logic [2:0] REG_PACE = 3'd4;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_mover_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8,
  parameter int PACE_W = 4,
  parameter int CFG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [LEN_W-1:0]  remaining,
  output logic [ADDR_W-1:0] src,
  output logic [ADDR_W-1:0] dst,
  output logic [LEN_W-1:0]  len,
  output logic [PACE_W-1:0] pace,
  output logic              paced,
  output logic              go
);
  logic [ADDR_W-1:0] src_q, src_n, dst_q, dst_n;
  logic [LEN_W-1:0]  len_q, len_n;
  logic [PACE_W-1:0] pace_q, pace_n;
  logic              paced_q, paced_n;

  always_comb begin
    src_n   = src_q;
    dst_n   = dst_q;
    len_n   = len_q;
    pace_n  = pace_q;
    paced_n = paced_q;
    if (cfg_we) begin
      case (cfg_addr)
        REG_SRC:  src_n   = cfg_wdata[ADDR_W-1:0];
        REG_DST:  dst_n   = cfg_wdata[ADDR_W-1:0];
        REG_LEN:  len_n   = cfg_wdata[LEN_W-1:0];
        REG_CTRL: paced_n = cfg_wdata[1];
        REG_PACE: pace_n  = cfg_wdata[PACE_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      dst_q   <= '0;
      len_q   <= '0;
      pace_q  <= '0;
      paced_q <= 1'b0;
    end else begin
      src_q   <= src_n;
      dst_q   <= dst_n;
      len_q   <= len_n;
      pace_q  <= pace_n;
      paced_q <= paced_n;
    end
  end

  always_comb begin
    case (cfg_addr)
      REG_SRC:  cfg_rdata = CFG_W'(src_q);
      REG_DST:  cfg_rdata = CFG_W'(dst_q);
      REG_LEN:  cfg_rdata = busy ? CFG_W'(remaining) : CFG_W'(len_q);
      REG_CTRL: cfg_rdata = CFG_W'({paced_q, done, busy});
      REG_PACE: cfg_rdata = CFG_W'(pace_q);
      default:  cfg_rdata = '0;
    endcase
  end

  assign go    = cfg_we && (cfg_addr == REG_CTRL) && cfg_wdata[0];
  assign src   = src_q;
  assign dst   = dst_q;
  assign len   = len_q;
  assign pace  = pace_q;
  assign paced = paced_q;
endmodule

// File: rtl/dma_pace.sv
module dma_pace #(
  parameter int PACE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PACE_W-1:0] load_val,
  output logic              expired
);
  logic [PACE_W-1:0] cnt_q, cnt_n;

  always_comb begin
    if (load)
      cnt_n = load_val;
    else if (cnt_q != '0)
      cnt_n = cnt_q - 1'b1;
    else
      cnt_n = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign expired = (cnt_q == '0);

  // R6: a loaded interval drains by one each cycle until it expires
  p_pace_drains_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_mover_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8,
  parameter int PACE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  input  logic [LEN_W-1:0]  len,
  input  logic              paced,
  input  logic [PACE_W-1:0] pace,
  input  logic              bus_gnt,
  input  logic              pace_expired,
  output logic              pace_load,
  output logic [PACE_W-1:0] pace_val,
  output logic              bus_req,
  output logic [ADDR_W-1:0] m_addr,
  output logic              m_rd,
  output logic              m_wr,
  output logic              busy,
  output logic              done,
  output logic              irq,
  output logic [LEN_W-1:0]  remaining
);
  eng_state_t        state_q, state_n;
  logic [ADDR_W-1:0] rd_ptr_q, rd_ptr_n, wr_ptr_q, wr_ptr_n;
  logic [LEN_W-1:0]  cnt_q, cnt_n;
  logic              done_q, done_n, irq_q, irq_n;

  assign pace_val = (pace == '0) ? '0 : pace - 1'b1;

  always_comb begin
    state_n   = state_q;
    rd_ptr_n  = rd_ptr_q;
    wr_ptr_n  = wr_ptr_q;
    cnt_n     = cnt_q;
    done_n    = done_q;
    irq_n     = 1'b0;
    pace_load = 1'b0;
    case (state_q)
      ST_IDLE: if (go) begin
        rd_ptr_n = src;
        wr_ptr_n = dst;
        cnt_n    = len;
        if (len == '0) begin
          done_n = 1'b1;
          irq_n  = 1'b1;
        end else begin
          done_n  = 1'b0;
          state_n = ST_REQ;
        end
      end
      ST_REQ: if (bus_gnt) state_n = ST_RD;
      ST_RD:  state_n = ST_WR;
      ST_WR: begin
        rd_ptr_n = rd_ptr_q + 1'b1;
        wr_ptr_n = wr_ptr_q + 1'b1;
        cnt_n    = cnt_q - 1'b1;
        if (cnt_q == LEN_W'(1)) begin
          state_n = ST_IDLE;
          done_n  = 1'b1;
          irq_n   = 1'b1;
        end else if (paced) begin
          state_n   = ST_GAP;
          pace_load = 1'b1;
        end else begin
          state_n = ST_RD;
        end
      end
      ST_GAP: if (pace_expired) state_n = ST_REQ;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      state_q  <= state_n;
      rd_ptr_q <= rd_ptr_n;
      wr_ptr_q <= wr_ptr_n;
      cnt_q    <= cnt_n;
      done_q   <= done_n;
      irq_q    <= irq_n;
    end
  end

  assign bus_req   = (state_q == ST_REQ) || (state_q == ST_RD) || (state_q == ST_WR);
  assign m_rd      = (state_q == ST_RD);
  assign m_wr      = (state_q == ST_WR);
  assign m_addr    = m_wr ? wr_ptr_q : rd_ptr_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign irq       = irq_q;
  assign remaining = cnt_q;

  // R3: the bus is driven only under grant
  p_drive_needs_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_rd || m_wr) |-> bus_gnt);
  // R4: every read cycle is followed by its write cycle
  p_read_then_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    m_rd |=> m_wr);
  // R7: the completion pulse lasts one cycle
  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R7: at the pulse the bus is released and done is visible
  p_irq_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done && !bus_req && !busy));
  // R8: a zero count finishes without requesting the bus
  p_zero_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy && len == '0) |=> (irq && !bus_req));
  // R9: a go during a read cycle does not disturb the transfer
  p_go_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (go && m_rd) |=> m_wr);
endmodule

// File: rtl/dma_mover.sv
module dma_mover #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 8,
  parameter int PACE_W = 4,
  parameter int CFG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [ADDR_W-1:0] m_addr,
  output logic              m_rd,
  output logic              m_wr,
  output logic [DATA_W-1:0] m_wdata,
  input  logic [DATA_W-1:0] m_rdata,
  output logic              irq
);
  logic [ADDR_W-1:0] src, dst;
  logic [LEN_W-1:0]  len, remaining;
  logic [PACE_W-1:0] pace, pace_val;
  logic              paced, go, busy, done, pace_load, pace_expired;

  dma_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PACE_W(PACE_W), .CFG_W(CFG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy), .done(done),
    .remaining(remaining), .src(src), .dst(dst), .len(len), .pace(pace),
    .paced(paced), .go(go)
  );

  dma_pace #(.PACE_W(PACE_W)) u_pace (
    .clk(clk), .rst_n(rst_n), .load(pace_load), .load_val(pace_val),
    .expired(pace_expired)
  );

  dma_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PACE_W(PACE_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .go(go), .src(src), .dst(dst), .len(len),
    .paced(paced), .pace(pace), .bus_gnt(bus_gnt), .pace_expired(pace_expired),
    .pace_load(pace_load), .pace_val(pace_val), .bus_req(bus_req),
    .m_addr(m_addr), .m_rd(m_rd), .m_wr(m_wr), .busy(busy), .done(done),
    .irq(irq), .remaining(remaining)
  );

  // read data arrives in the write cycle and is forwarded unchanged
  assign m_wdata = m_rdata;
endmodule

// File: tb/dma_mover_test.sv
module dma_mover_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] SENT = 16'hDEAD;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [15:0] cfg_wdata, cfg_rdata;
  logic        bus_req, bus_gnt, m_rd, m_wr, irq;
  logic [15:0] m_addr, m_wdata, m_rdata;

  int checks = 0, errors = 0;
  logic [15:0] mem [256];
  int lat = 0, gnt_cnt = 0;

  // monitor state
  bit run_active = 0, cur_paced = 0;
  int cur_len = 0, cur_src = 0, cur_dst = 0, exp_gap = 1;
  int wr_idx = 0, wr_bad = 0, drive_bad = 0, rises = 0, gap_bad = 0;
  int irq_cnt = 0, irq_bad = 0, rem_bad = 0, low_run = 0;
  bit prev_req = 0, prev_wr = 0;
  int cycles = 0;

  dma_mover uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .m_addr(m_addr), .m_rd(m_rd), .m_wr(m_wr),
    .m_wdata(m_wdata), .m_rdata(m_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] pat(input int a);
    return 16'(a * 37 + 5);
  endfunction

  // memory: registered read, write on edge
  always @(posedge clk) begin
    if (m_rd) m_rdata <= mem[m_addr[7:0]];
    if (m_wr) mem[m_addr[7:0]] <= m_wdata;
  end

  // arbiter: grant after lat cycles of request, drop one cycle after release
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_gnt <= 1'b0; gnt_cnt <= 0;
    end else if (!bus_req) begin
      bus_gnt <= 1'b0; gnt_cnt <= 0;
    end else if (gnt_cnt >= lat) begin
      bus_gnt <= 1'b1;
    end else begin
      gnt_cnt <= gnt_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) if (run_active) begin
    if ((m_rd || m_wr) && !bus_gnt) drive_bad++;             // R3, R10
    if (m_wr) begin                                          // R4
      if (m_addr != 16'(cur_dst + wr_idx) || m_wdata != pat(cur_src + wr_idx)) wr_bad++;
      wr_idx++;
    end
    if (!m_wr && !cfg_we && cfg_addr == 3'd2 && wr_idx < cur_len
        && cfg_rdata != 16'(cur_len - wr_idx)) rem_bad++;    // R11
    if (bus_req && !prev_req) begin                          // R5, R6
      if (cur_paced && rises > 0 && low_run != exp_gap) gap_bad++;
      rises++;
    end
    if (bus_req) low_run = 0; else low_run++;
    if (irq) begin                                           // R7, R8
      irq_cnt++;
      if (bus_req) irq_bad++;
      if (cur_len != 0 && !(prev_wr && wr_idx == cur_len)) irq_bad++;
    end
    prev_req = bus_req;
    prev_wr  = m_wr;
  end

  task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = 3'd2;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
    cfg_addr = 3'd2;
  endtask

  task automatic run(input int n, input bit pm, input int p, input int l,
                     input bit second_go);
    logic [15:0] st;
    int waited;
    cur_src = 16; cur_dst = 128;
    for (int i = 0; i < 8; i++) begin
      mem[cur_src + i] = pat(cur_src + i);
      mem[cur_dst + i] = SENT;
    end
    lat = l;
    reg_wr(3'd0, 16'(cur_src));
    reg_wr(3'd1, 16'(cur_dst));
    reg_wr(3'd2, 16'(n));
    reg_wr(3'd4, 16'(p));
    @(posedge clk);
    cur_len = n; cur_paced = pm; exp_gap = (p == 0) ? 1 : p;
    wr_idx = 0; wr_bad = 0; drive_bad = 0; rises = 0; gap_bad = 0;
    irq_cnt = 0; irq_bad = 0; rem_bad = 0; low_run = 0;
    prev_req = 0; prev_wr = 0; run_active = 1;
    reg_wr(3'd3, {14'd0, pm, 1'b1});
    if (n > 0) check(bus_req == 1'b1, "R3 req after go", bus_req, 1);
    if (second_go) begin
      while (wr_idx < 2) @(negedge clk);
      reg_wr(3'd3, {14'd0, pm, 1'b1});
    end
    waited = 0;
    while (irq_cnt == 0 && waited < 2000) begin
      @(negedge clk); waited++;
    end
    repeat (4) @(negedge clk);
    run_active = 0;
    reg_rd(3'd3, st);
    check(irq_cnt == 1, "R7 irq once", irq_cnt, 1);
    check(irq_bad == 0, "R7 irq timing", irq_bad, 0);
    check(st[1:0] == 2'b10, "R7 status done idle", st[1:0], 2);
    check(wr_idx == n, "R9 word count", wr_idx, n);
    check(wr_bad == 0, "R4 write addr data", wr_bad, 0);
    check(drive_bad == 0, "R10 no drive without grant", drive_bad, 0);
    check(rem_bad == 0, "R11 remaining count", rem_bad, 0);
    if (n == 0)       check(rises == 0, "R8 no request", rises, 0);
    else if (!pm)     check(rises == 1, "R5 single request", rises, 1);
    else              check(rises == n, "R6 request per word", rises, n);
    check(gap_bad == 0, "R6 gap length", gap_bad, 0);
    for (int i = 0; i < n; i++)
      check(mem[cur_dst + i] == pat(cur_src + i), "R7 dest word", mem[cur_dst + i], pat(cur_src + i));
    check(mem[cur_dst + n] == SENT, "R7 dest guard", mem[cur_dst + n], SENT);
  endtask

  initial begin
    logic [15:0] d;
    int lens [4] = '{0, 1, 2, 5};
    cfg_we = 1'b0; cfg_addr = 3'd2; cfg_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!bus_req && !m_rd && !m_wr && !irq, "R1 outputs idle", {bus_req, m_rd, m_wr, irq}, 0);
    rst_n = 1'b1;
    reg_rd(3'd3, d);
    check(d[1:0] == 2'b00, "R1 status clear", d[1:0], 0);

    reg_wr(3'd0, 16'h1234); reg_rd(3'd0, d);
    check(d == 16'h1234, "R2 src readback", d, 16'h1234);
    reg_wr(3'd1, 16'h0BEE); reg_rd(3'd1, d);
    check(d == 16'h0BEE, "R2 dst readback", d, 16'h0BEE);
    reg_wr(3'd4, 16'd9); reg_rd(3'd4, d);
    check(d == 16'd9, "R2 pace readback", d, 9);
    reg_wr(3'd2, 16'd0);
    reg_wr(3'd3, 16'h0002); reg_rd(3'd3, d);
    check(d[2] == 1'b1, "R2 paced flag", d[2], 1);

    foreach (lens[k])
      for (int l = 0; l < 2; l++) begin
        run(lens[k], 1'b0, 0, l * 3, 1'b0);
        for (int p = 0; p < 2; p++)
          run(lens[k], 1'b1, p * 2, l * 3, 1'b0);
      end

    run(6, 1'b0, 0, 0, 1'b1);   // R9 go while busy
    run(5, 1'b1, 3, 2, 1'b1);   // R9 in paced mode

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule